// File: doc/BRIEF.md
# Vector Accumulator with Offset Read

This block is a single vector accumulator slot for an array datapath. It holds two 32-bit registers. The first is the operand register. It is written from a routing bus whenever a load strobe is given. A vector is placed there right-justified, with its last element in bit 0.

A 5-bit offset picks how that register is seen on the view output. The view is the operand shifted toward the high end by the offset. Bits pushed past the top are lost and the vacated low bits read as zero. This lets a vector of up to 32 elements be read back with any wanted part aligned to the top of the bus.

The second register is the running sum. An accumulate strobe adds the operand into it, modulo 2^32. A clear strobe zeroes it. Repeated accumulation gives a reduction. Capturing the sum after every step gives a scan, and a step pulse marks each new sum for that purpose. The sum has its own registered output bus.

Top module: `vector_accum`

## Requirements
- R1: After reset the operand register and the running sum are zero and stepValid is low, so offsetView and sumOut read 0.
- R2: When loadStb is high at a rising edge, the operand register takes loadData, and offsetView shows the new value from the next cycle on.
- R3: offsetView equals the operand register shifted left by offset (0 to 31), computed with no clock delay. Bits that would reach index 32 or above are dropped, and bits below index offset read 0.
- R4: When accStb is high and clrStb is low at a rising edge, sumOut becomes the previous sumOut plus the operand register, modulo 2^32, in the next cycle.
- R5: stepValid is high for exactly the one cycle after each accepted accumulate, and low in every other cycle.
- R6: When clrStb is high at a rising edge, sumOut is 0 in the next cycle. Clear wins over an accumulate in the same cycle, and that cycle produces no stepValid.
- R7: When loadStb and accStb are both high at the same edge, the sum adds the operand value held before that load.
- R8: With accStb and clrStb both low, sumOut keeps its value. A load alone or a change of offset does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Write loadData into the operand register |
| loadData | input | 32 | Routing bus value, vector right-justified |
| offset | input | 5 | Left-shift amount for the view output |
| accStb | input | 1 | Add the operand into the running sum |
| clrStb | input | 1 | Zero the running sum |
| offsetView | output | 32 | Operand register shifted left by offset |
| sumOut | output | 32 | Registered running sum |
| stepValid | output | 1 | Marks a fresh sum after an accumulate |

## Verification
A wrong operand register shows at offsetView as soon as it is loaded, at any offset, because the view has no register in its path. A faulty shifter stage shows only for offsets that have that stage's bit set. The offsets chosen therefore include 0, 31 and values with single bits set. A wrong sum is seen on sumOut one cycle after the accumulate that caused it, and it stays wrong in every later scan value until a clear. A missing or extra step pulse breaks the pairing between expected and observed scan values in the same cycle.

// File: rtl/vacc_pkg.sv
package vacc_pkg;
  typedef struct packed {
    logic loadA;
    logic clearB;
    logic addB;
  } vaccCtrl_t;
endpackage

// File: rtl/vacc_ctrl.sv
module vacc_ctrl
  import vacc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadStb,
  input  logic      accStb,
  input  logic      clrStb,
  output vaccCtrl_t ctrl,
  output logic      stepValid
);
  logic addGo;

  // clear has priority over accumulate (R6)
  assign addGo = accStb & ~clrStb;

  always_comb begin
    ctrl.loadA  = loadStb;
    ctrl.clearB = clrStb;
    ctrl.addB   = addGo;
  end

  // one-cycle marker aligned with the new sum (R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepValid <= 1'b0;
    else       stepValid <= addGo;
  end
endmodule

// File: rtl/vacc_datapath.sv
module vacc_datapath
  import vacc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vaccCtrl_t         ctrl,
  input  logic [DATA_W-1:0] loadData,
  input  logic [OFF_W-1:0]  offset,
  output logic [DATA_W-1:0] aValue,
  output logic [DATA_W-1:0] offsetView,
  output logic [DATA_W-1:0] sumOut
);
  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;
  logic [DATA_W-1:0] stage [OFF_W+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           regA <= '0;
    else if (ctrl.loadA) regA <= loadData;
  end

  // the add reads regA before any same-edge load (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            regB <= '0;
    else if (ctrl.clearB) regB <= '0;
    else if (ctrl.addB)   regB <= regB + regA;
  end

  // logarithmic left shifter, one stage per offset bit (R3)
  assign stage[0] = regA;
  for (genvar k = 0; k < OFF_W; k++) begin : g_shift
    localparam int SH = 1 << k;
    assign stage[k+1] = offset[k] ? {stage[k][DATA_W-1-SH:0], {SH{1'b0}}}
                                  : stage[k];
  end

  assign aValue     = regA;
  assign offsetView = stage[OFF_W];
  assign sumOut     = regB;
endmodule

// File: rtl/vector_accum.sv
module vector_accum
  import vacc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [DATA_W-1:0] loadData,
  input  logic [OFF_W-1:0]  offset,
  input  logic              accStb,
  input  logic              clrStb,
  output logic [DATA_W-1:0] offsetView,
  output logic [DATA_W-1:0] sumOut,
  output logic              stepValid
);
  vaccCtrl_t         ctrl;
  logic [DATA_W-1:0] aValue;

  vacc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .accStb(accStb),
    .clrStb(clrStb), .ctrl(ctrl), .stepValid(stepValid)
  );

  vacc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loadData(loadData),
    .offset(offset), .aValue(aValue), .offsetView(offsetView),
    .sumOut(sumOut)
  );
endmodule

// File: rtl/vacc_checker.sv
module vacc_checker #(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic [DATA_W-1:0] loadData,
  input logic [OFF_W-1:0]  offset,
  input logic              accStb,
  input logic              clrStb,
  input logic [DATA_W-1:0] aValue,
  input logic [DATA_W-1:0] offsetView,
  input logic [DATA_W-1:0] sumOut,
  input logic              stepValid
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> aValue == $past(loadData));

  assert_view_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    offsetView[offset] == aValue[0]);

  assert_view_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    offsetView[DATA_W-1] == aValue[DATA_W-1-offset]);

  assert_add_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accStb && !clrStb) |=> sumOut == $past(sumOut) + $past(aValue));

  assert_step_hi_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accStb && !clrStb) |=> stepValid);

  assert_step_lo_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(accStb && !clrStb) |=> !stepValid);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> sumOut == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!accStb && !clrStb) |=> $stable(sumOut));
endmodule

bind vector_accum vacc_checker #(.DATA_W(DATA_W)) u_vacc_checker (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadData(loadData),
  .offset(offset), .accStb(accStb), .clrStb(clrStb), .aValue(aValue),
  .offsetView(offsetView), .sumOut(sumOut), .stepValid(stepValid)
);

// File: tb/vector_accum_test.sv
`timescale 1ns/1ps
module vector_accum_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [31:0] loadData = '0;
  logic [4:0]  offset = '0;
  logic        accStb = 1'b0;
  logic        clrStb = 1'b0;
  logic [31:0] offsetView, sumOut;
  logic        stepValid;

  int checks = 0;
  int errors = 0;
  logic [31:0] modelA = '0;
  logic [31:0] modelB = '0;
  logic [31:0] expQ [$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  vector_accum uut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadData(loadData),
    .offset(offset), .accStb(accStb), .clrStb(clrStb),
    .offsetView(offsetView), .sumOut(sumOut), .stepValid(stepValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every step pulse must match the next scoreboard entry (R4, R5)
  always @(negedge clk) begin
    if (rstN && stepValid) begin
      if (expQ.size() == 0) check("R5 unexpected step", 32'd1, 32'd0);
      else check("R4 scan value", sumOut, expQ.pop_front());
    end
  end

  task automatic doLoad(input logic [31:0] d);
    @(negedge clk); loadStb = 1'b1; loadData = d;
    @(negedge clk); loadStb = 1'b0;
    modelA = d;
  endtask

  task automatic doAcc();
    @(negedge clk); accStb = 1'b1;
    modelB = modelB + modelA;
    expQ.push_back(modelB);
    @(negedge clk); accStb = 1'b0;
  endtask

  task automatic viewAt(input logic [4:0] p, input string req);
    offset = p; #1;
    check(req, offsetView, modelA << p);
  endtask

  initial begin
    #2000000; check("watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 view", offsetView, 32'd0);
    check("R1 sum", sumOut, 32'd0);
    check("R1 step", {31'd0, stepValid}, 32'd0);
    rstN = 1'b1;

    doLoad(32'h8000_00F1);
    viewAt(5'd0, "R2 load view");
    viewAt(5'd1, "R3 offset 1");
    viewAt(5'd4, "R3 offset 4");
    viewAt(5'd16, "R3 offset 16");
    viewAt(5'd31, "R3 offset 31");
    doLoad(32'h0000_0007);
    viewAt(5'd29, "R3 offset 29 drop");
    viewAt(5'd10, "R3 offset 10");
    check("R8 load keeps sum", sumOut, 32'd0);

    // reduction and scan over several operands
    doAcc(); doAcc();
    doLoad(32'h0000_1000); doAcc();
    doLoad(32'h1234_5678); doAcc();
    check("R4 reduce result", sumOut, modelB);
    @(negedge clk);
    check("R5 no step when idle", {31'd0, stepValid}, 32'd0);

    // wrap modulo 2^32
    doLoad(32'hFFFF_FFFF); doAcc();
    check("R4 wrap", sumOut, modelB);

    // hold with offset change
    offset = 5'd3; repeat (3) @(negedge clk);
    check("R8 hold", sumOut, modelB);

    // clear alone
    @(negedge clk); clrStb = 1'b1;
    @(negedge clk); clrStb = 1'b0; modelB = '0;
    check("R6 clear", sumOut, 32'd0);

    // clear beats accumulate
    doLoad(32'h0000_0055); doAcc();
    @(negedge clk); clrStb = 1'b1; accStb = 1'b1;
    @(negedge clk); clrStb = 1'b0; accStb = 1'b0; modelB = '0;
    check("R6 clear priority", sumOut, 32'd0);
    check("R6 no step", {31'd0, stepValid}, 32'd0);

    // load and accumulate together use the old operand
    @(negedge clk); loadStb = 1'b1; loadData = 32'h0000_0300; accStb = 1'b1;
    modelB = modelB + modelA; expQ.push_back(modelB);
    @(negedge clk); loadStb = 1'b0; accStb = 1'b0; modelA = 32'h0000_0300;
    check("R7 old operand", sumOut, 32'h0000_0055);
    viewAt(5'd0, "R7 new operand visible");
    doAcc();
    check("R7 following add", sumOut, 32'h0000_0355);

    repeat (2) @(negedge clk);
    check("R5 all steps seen", expQ.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule